// File: doc/BRIEF.md
# Dual-Enable Static Memory Array

This block is a synthesizable model of a word-wide static memory selected by two chip enables of opposite polarity. A small truth-table decoder turns the enable pair, the output-enable and the read/write select into one of four operating modes: standby, read, write and output-deselect. Only the read mode drives the data port. In every other mode the port is released. The block reports the decoded mode and a low-power flag, so that a surrounding model can account for power states.

The bidirectional data pins are split into a data-in bus, a data-out bus and a single output-enable, which a pad wrapper can combine into a tri-state pin. Reads are asynchronous: the addressed word appears combinationally. Writes are captured on the rising edge of the clock that the enclosing simulation model supplies. The array has no reset and keeps its contents while the block is in standby. The address and word widths are parameters. With a 17-bit address and 8-bit words the block holds 131,072 bytes. The default address width is kept small so that default elaboration stays cheap.

Top module: `dual_enable_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. A word written at any address, including address 0 and the highest address, reads back unchanged, and writes to other addresses do not alter it.
- R2: The block is selected only when `sel_n` is 0 and `sel_p` is 1. With any other enable combination, and for any value of the other inputs, `mode` is 2'b00, `standby` is 1, `dout_en` is 0, and a clock edge writes nothing.
- R3: When the block is selected with `rd_wr` 0, `mode` is 2'b10 and the word on `din` is stored at `addr` on each rising clock edge. A read of that address afterwards returns it.
- R4: When the block is selected with `rd_wr` 1 and `oe_n` 0, `mode` is 2'b01, `dout_en` is 1, and `dout` carries the word stored at `addr`.
- R5: In write mode `oe_n` has no effect. `dout_en` stays 0 with `oe_n` at either level.
- R6: When the block is selected with `rd_wr` 1 and `oe_n` 1, `mode` is 2'b11, `dout_en` is 0 and `standby` is 0.
- R7: With DOUT_MASK=1 (the default), `dout` is all zeros whenever `dout_en` is 0.
- R8: If `rd_wr` is already low when the block becomes selected, or falls in the same cycle, `dout_en` never rises during that cycle.
- R9: Words stored before a period of standby are still present after the block is selected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write capture clock from the enclosing model |
| sel_n | input | 1 | Active-low chip enable |
| sel_p | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| rd_wr | input | 1 | 1 selects read, 0 selects write |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the pin |
| dout | output | DATA_W | Read data toward the pin |
| dout_en | output | 1 | Pin driver enable, high only in read mode |
| standby | output | 1 | Low-power state flag |
| mode | output | 2 | Decoded mode: 00 standby, 01 read, 10 write, 11 output-deselect |

## Verification
The bench builds the block with ADDR_W=8 and DATA_W=8. At that size it can write a distinct pattern to every one of the 256 words and read all of them back, so both the lowest and the highest address and any aliasing between addresses are covered. The default DOUT_MASK=1 is kept, which makes the released data bus observable as zero. Every non-selecting enable combination is crossed with each level of the read/write and output-enable controls, and a write attempted in standby is then shown to have left memory untouched.

// File: rtl/sram_pkg.sv
package sram_pkg;

   typedef enum logic [1:0] {
      MODE_STBY  = 2'b00,
      MODE_READ  = 2'b01,
      MODE_WRITE = 2'b10,
      MODE_DESEL = 2'b11
   } sram_mode_t;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_pkg::*;
(
   input  logic       sel_n,
   input  logic       sel_p,
   input  logic       oe_n,
   input  logic       rd_wr,
   output sram_mode_t mode,
   output logic       rd_go,
   output logic       wr_go,
   output logic       low_pwr
);

   logic picked;

   always_comb begin
      picked = !sel_n && sel_p;
      if (!picked)
         mode = MODE_STBY;
      else if (!rd_wr)
         mode = MODE_WRITE;
      else if (!oe_n)
         mode = MODE_READ;
      else
         mode = MODE_DESEL;
   end

   assign rd_go   = (mode == MODE_READ);
   assign wr_go   = (mode == MODE_WRITE);
   assign low_pwr = (mode == MODE_STBY);

endmodule

// File: rtl/sram_store.sv
module sram_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_go)
         cells[addr] <= wdata;
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/sram_out_path.sv
module sram_out_path #(
   parameter int DATA_W    = 8,
   parameter bit DOUT_MASK = 1'b1
) (
   input  logic              rd_go,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   assign dout_en = rd_go;

   generate
      if (DOUT_MASK) begin : g_mask
         assign dout = rd_go ? rdata : '0;
      end else begin : g_pass
         assign dout = rdata;
      end
   endgenerate

endmodule

// File: rtl/dual_enable_sram.sv
module dual_enable_sram
   import sram_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 8,
   parameter bit DOUT_MASK = 1'b1
) (
   input  logic              clk,
   input  logic              sel_n,
   input  logic              sel_p,
   input  logic              oe_n,
   input  logic              rd_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              standby,
   output logic [1:0]        mode
);

   generate
      if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
         $error("dual_enable_sram: ADDR_W out of range 1..20");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("dual_enable_sram: DATA_W out of range 1..64");
      end
   endgenerate

   sram_mode_t        cur_mode;
   logic              rd_go;
   logic              wr_go;
   logic [DATA_W-1:0] rdata;

   sram_mode_decode i_decode (
      .sel_n   (sel_n),
      .sel_p   (sel_p),
      .oe_n    (oe_n),
      .rd_wr   (rd_wr),
      .mode    (cur_mode),
      .rd_go   (rd_go),
      .wr_go   (wr_go),
      .low_pwr (standby)
   );

   sram_store #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_store (
      .clk   (clk),
      .wr_go (wr_go),
      .addr  (addr),
      .wdata (din),
      .rdata (rdata)
   );

   sram_out_path #(
      .DATA_W    (DATA_W),
      .DOUT_MASK (DOUT_MASK)
   ) i_out (
      .rd_go   (rd_go),
      .rdata   (rdata),
      .dout    (dout),
      .dout_en (dout_en)
   );

   assign mode = cur_mode;

endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 8,
   parameter bit DOUT_MASK = 1'b1
) (
   input logic              clk,
   input logic              sel_n,
   input logic              sel_p,
   input logic              oe_n,
   input logic              rd_wr,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en,
   input logic              standby,
   input logic [1:0]        mode
);

   logic picked;
   assign picked = !sel_n && sel_p;

   // R2
   standby_state_chk: assert property (@(posedge clk)
      !picked |-> (standby && !dout_en && mode == 2'b00));

   // R3
   write_readback_chk: assert property (@(posedge clk)
      (picked && !rd_wr) |=>
         ((mode == 2'b01 && addr == $past(addr)) ? (dout == $past(din)) : 1'b1));

   // R4
   read_drive_chk: assert property (@(posedge clk)
      (picked && rd_wr && !oe_n) |-> (dout_en && !standby && mode == 2'b01));

   // R5
   write_no_drive_chk: assert property (@(posedge clk)
      (picked && !rd_wr) |-> (!dout_en && mode == 2'b10));

   // R6
   desel_state_chk: assert property (@(posedge clk)
      (picked && rd_wr && oe_n) |-> (!dout_en && !standby && mode == 2'b11));

   // R7
   masked_bus_chk: assert property (@(posedge clk)
      (DOUT_MASK && !dout_en) |-> (dout == '0));

   // R8
   wr_low_quiet_chk: assert property (@(posedge clk)
      !rd_wr |-> !dout_en);

endmodule

bind dual_enable_sram sram_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .DOUT_MASK (DOUT_MASK)
) i_sram_chk (
   .clk     (clk),
   .sel_n   (sel_n),
   .sel_p   (sel_p),
   .oe_n    (oe_n),
   .rd_wr   (rd_wr),
   .addr    (addr),
   .din     (din),
   .dout    (dout),
   .dout_en (dout_en),
   .standby (standby),
   .mode    (mode)
);

// File: tb/test_dual_enable_sram.sv
module test_dual_enable_sram;

   localparam int CLK_P  = 10;
   localparam int AW     = 8;
   localparam int DW     = 8;
   localparam int NWORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          sel_n = 1'b1;
   logic          sel_p = 1'b0;
   logic          oe_n = 1'b1;
   logic          rd_wr = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;
   logic          standby;
   logic [1:0]    mode;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   dual_enable_sram #(.ADDR_W(AW), .DATA_W(DW)) i_dual_enable_sram (
      .clk(clk), .sel_n(sel_n), .sel_p(sel_p), .oe_n(oe_n), .rd_wr(rd_wr),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .standby(standby), .mode(mode)
   );

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      return DW'((a * 29 + 8'h3C + salt * 7) ^ 8'hA5);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic sn, input logic sp, input logic on,
                        input logic rw, input int a, input logic [DW-1:0] d);
      @(negedge clk);
      sel_n = sn; sel_p = sp; oe_n = on; rd_wr = rw;
      addr = AW'(a); din = d;
      #1;
   endtask

   task automatic wr_word(input int a, input logic [DW-1:0] d, input logic on);
      drive(1'b0, 1'b1, on, 1'b0, a, d);
      @(posedge clk);
      #1;
   endtask

   task automatic rd_expect(input string req, input int a, input logic [DW-1:0] d);
      drive(1'b0, 1'b1, 1'b0, 1'b1, a, '0);
      chk(req, {31'd0, dout_en}, 32'd1);
      chk(req, {24'd0, dout}, {24'd0, d});
   endtask

   task automatic t_initial;
      drive(1'b1, 1'b0, 1'b0, 1'b1, 0, '0);
      chk("R2 initial standby", {31'd0, standby}, 32'd1);
      chk("R2 initial mode", {30'd0, mode}, 32'd0);
      chk("R2 initial dout_en", {31'd0, dout_en}, 32'd0);
      chk("R7 initial dout", {24'd0, dout}, 32'd0);
   endtask

   task automatic t_fill_all;
      for (int a = 0; a < NWORDS; a++) wr_word(a, pat(a, 0), a[0]);
      for (int a = 0; a < NWORDS; a++) rd_expect("R1 R3 R4 readback", a, pat(a, 0));
      rd_expect("R1 lowest address", 0, pat(0, 0));
      rd_expect("R1 highest address", NWORDS - 1, pat(NWORDS - 1, 0));
   endtask

   task automatic t_standby_grid;
      for (int e = 0; e < 3; e++) begin
         for (int c = 0; c < 4; c++) begin
            logic sn, sp;
            sn = (e != 0); sp = (e == 2);
            if (e == 0) sp = 1'b0;
            drive(sn, sp, c[0], c[1], 5, 8'h5A);
            chk("R2 standby flag", {31'd0, standby}, 32'd1);
            chk("R2 standby mode", {30'd0, mode}, 32'd0);
            chk("R2 standby no drive", {31'd0, dout_en}, 32'd0);
            chk("R7 standby dout zero", {24'd0, dout}, 32'd0);
            @(posedge clk);
         end
      end
      rd_expect("R2 standby write ignored", 5, pat(5, 0));
   endtask

   task automatic t_deselect;
      drive(1'b0, 1'b1, 1'b1, 1'b1, 9, '0);
      chk("R6 deselect mode", {30'd0, mode}, 32'd3);
      chk("R6 deselect no drive", {31'd0, dout_en}, 32'd0);
      chk("R6 deselect not standby", {31'd0, standby}, 32'd0);
      chk("R7 deselect dout zero", {24'd0, dout}, 32'd0);
   endtask

   task automatic t_write_oe_ignored;
      drive(1'b0, 1'b1, 1'b0, 1'b0, 20, 8'hC3);
      chk("R5 write oe low mode", {30'd0, mode}, 32'd2);
      chk("R5 write oe low no drive", {31'd0, dout_en}, 32'd0);
      @(posedge clk); #1;
      drive(1'b0, 1'b1, 1'b1, 1'b0, 21, 8'h3C);
      chk("R5 write oe high no drive", {31'd0, dout_en}, 32'd0);
      chk("R7 write dout zero", {24'd0, dout}, 32'd0);
      @(posedge clk); #1;
      rd_expect("R3 write with oe low", 20, 8'hC3);
      rd_expect("R3 write with oe high", 21, 8'h3C);
      rd_expect("R1 neighbour untouched", 22, pat(22, 0));
   endtask

   task automatic t_select_while_writing;
      rd_expect("R8 setup read", 30, pat(30, 0));
      @(negedge clk);
      rd_wr = 1'b0; din = 8'h99; #1;
      chk("R8 same-cycle strobe no drive", {31'd0, dout_en}, 32'd0);
      #2;
      chk("R8 same-cycle strobe later", {31'd0, dout_en}, 32'd0);
      @(posedge clk); #1;
      drive(1'b1, 1'b1, 1'b0, 1'b0, 31, 8'h66);
      chk("R8 strobe before select standby", {31'd0, dout_en}, 32'd0);
      @(negedge clk);
      sel_n = 1'b0; #1;
      chk("R8 select after strobe no drive", {31'd0, dout_en}, 32'd0);
      chk("R8 select after strobe mode", {30'd0, mode}, 32'd2);
      @(posedge clk); #1;
      rd_expect("R8 write taken", 30, 8'h99);
      rd_expect("R8 second write taken", 31, 8'h66);
   endtask

   task automatic t_retention;
      wr_word(40, 8'hE1, 1'b1);
      wr_word(NWORDS - 1, 8'h1E, 1'b1);
      for (int k = 0; k < 6; k++) drive(k[0], 1'b0, 1'b0, 1'b0, 40, 8'h00);
      rd_expect("R9 retained word", 40, 8'hE1);
      rd_expect("R9 retained top word", NWORDS - 1, 8'h1E);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      t_initial();
      t_fill_all();
      t_standby_grid();
      t_deselect();
      t_write_oe_ignored();
      t_select_while_writing();
      t_retention();
      finish_run();
   end

endmodule